// File: doc/BRIEF.md
# Postbyte Indexed Address Generator

This block turns an indexed-addressing postbyte, along with the up to two extension bytes that follow it, into a 16-bit operand address. The postbyte selects the base register, which may be X, Y, SP or PC. It also selects how the offset is formed. The offset can be a signed constant of 5, 9 or 16 bits. It can instead be the unsigned contents of accumulator A, B or the 16-bit D (A as high byte, B as low byte). The last choice is an automatic step of the base register, taken before or after the address is formed. X and Y share the same encodings, so neither register costs extra bytes or cycles.

The block is purely combinational and holds no state. An instruction sequencer presents the postbyte, the bytes after it and the current register values. In the same evaluation it receives four things:

- the effective address;
- how many extension bytes were consumed, so the fetch pointer can advance;
- a request to write an updated value back into the base register, for the auto-step modes;
- an illegal-encoding flag for postbytes outside the supported set.

Opcode fetch, memory access and indirect modes are handled elsewhere.

Top module: `idx_addr_gen`

## Requirements
- R1: When postbyte bit 5 is 0, bits 7:6 pick the base (00 X, 01 Y, 10 SP, 11 PC). The address is the base plus bits 4:0 taken as a signed 5-bit value, the extension count is 0 and there is no writeback.
- R2: A postbyte of the form 111bb00s selects base bb (same code as R1) with a signed 9-bit offset. Bit 0 is the sign bit and the first extension byte supplies the low 8 bits. The extension count is 1.
- R3: A postbyte of the form 111bb010 adds a 16-bit offset to base bb. The first extension byte is the high byte and the second is the low byte. The extension count is 2.
- R4: A postbyte of the form 111bb1aa with aa in 00, 01 or 10 adds accumulator A, B or D to base bb. A and B are zero-extended, and D is A in the high byte with B in the low byte. The extension count is 0.
- R5: A postbyte with bit 5 set and bits 7:6 not 11 is an auto-step mode on base bits 7:6 (X, Y or SP). Bits 3:0 give the step: 0 to 7 mean +1 to +8, and 8 to 15 mean -8 to -1. The writeback enable is 1, the writeback select equals bits 7:6, the new value is the base plus the step, and the extension count is 0.
- R6: In an auto-step mode with bit 4 equal to 0 (pre), the address equals the updated value.
- R7: In an auto-step mode with bit 4 equal to 1 (post), the address equals the unmodified base value.
- R8: All address and writeback arithmetic wraps modulo 2^16.
- R9: The postbytes 111bb011 and 111bb111 are illegal. For them the illegal flag is 1, the writeback enable is 0, and the address and extension count are 0.
- R10: Constant-offset and accumulator-offset modes never request a writeback.
- R11: Every encoding covered by R1 to R5 leaves the illegal flag at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| postbyte | input | 8 | Indexed-addressing postbyte |
| ext_hi | input | 8 | First extension byte after the postbyte |
| ext_lo | input | 8 | Second extension byte |
| reg_x | input | 16 | Index register X |
| reg_y | input | 16 | Index register Y |
| reg_sp | input | 16 | Stack pointer |
| reg_pc | input | 16 | Program counter value used as base |
| acc_a | input | 8 | Accumulator A |
| acc_b | input | 8 | Accumulator B |
| ea | output | 16 | Effective operand address |
| ext_cnt | output | 2 | Extension bytes consumed (0 to 2) |
| wb_en | output | 1 | Base register writeback request |
| wb_sel | output | 2 | Register to write (00 X, 01 Y, 10 SP) |
| wb_val | output | 16 | Updated base register value |
| illegal | output | 1 | Unsupported postbyte encoding |

## Verification
In the auto-step modes, the address output and the register writeback are produced in the same evaluation. Which of the two values the address takes depends on postbyte bit 4. The bench therefore applies pre- and post-step postbytes with increments and decrements at both ends of the step range. Each time it compares the address and the writeback value against values worked out by hand. It also places the base register next to the 16-bit boundary, so that wraparound and writeback meet in the same case.

// File: rtl/idx_addr_pkg.sv
// Package: shared types for the postbyte indexed address generator.
// Assumes an 8-bit postbyte whose field layout is fixed by the encoding.
package idx_addr_pkg;

    typedef enum logic [1:0] {
        BASE_X  = 2'd0,
        BASE_Y  = 2'd1,
        BASE_SP = 2'd2,
        BASE_PC = 2'd3
    } base_e;

    typedef enum logic [2:0] {
        MD_K5   = 3'd0,
        MD_K9   = 3'd1,
        MD_K16  = 3'd2,
        MD_ACC  = 3'd3,
        MD_PRE  = 3'd4,
        MD_POST = 3'd5,
        MD_BAD  = 3'd6
    } mode_e;

    typedef enum logic [1:0] {
        OFS_A    = 2'd0,
        OFS_B    = 2'd1,
        OFS_D    = 2'd2,
        OFS_NONE = 2'd3
    } acc_e;

    typedef struct packed {
        mode_e       mode;
        base_e       base;
        acc_e        acc;
        logic [3:0]  step;
        logic [4:0]  k5;
        logic        k9_sign;
    } dec_t;

endpackage

// File: rtl/idx_decode.sv
// Module: idx_decode
// Splits a postbyte into mode, base register, accumulator choice and
// immediate fields. Pure combinational; assumes an 8-bit postbyte.
module idx_decode
    import idx_addr_pkg::*;
(
    input  logic [7:0] pb,
    output dec_t       dec
);

    // Classify the postbyte and extract its fields.
    always_comb begin
        dec         = '0;
        dec.mode    = MD_BAD;
        dec.acc     = OFS_NONE;
        dec.base    = BASE_X;
        if (!pb[5]) begin
            dec.mode = MD_K5;
            dec.base = base_e'(pb[7:6]);
            dec.k5   = pb[4:0];
        end else if (pb[7:6] != 2'b11) begin
            dec.mode = pb[4] ? MD_POST : MD_PRE;
            dec.base = base_e'(pb[7:6]);
            dec.step = pb[3:0];
        end else begin
            dec.base = base_e'(pb[4:3]);
            if (!pb[2]) begin
                if (!pb[1]) begin
                    dec.mode    = MD_K9;
                    dec.k9_sign = pb[0];
                end else if (!pb[0]) begin
                    dec.mode = MD_K16;
                end else begin
                    dec.mode = MD_BAD;
                end
            end else begin
                unique case (pb[1:0])
                    2'b00: begin dec.mode = MD_ACC; dec.acc = OFS_A; end
                    2'b01: begin dec.mode = MD_ACC; dec.acc = OFS_B; end
                    2'b10: begin dec.mode = MD_ACC; dec.acc = OFS_D; end
                    default: dec.mode = MD_BAD;
                endcase
            end
        end
    end

endmodule

// File: rtl/idx_base_mux.sv
// Module: idx_base_mux
// Selects one of the four base registers with an and-or tree.
// Assumes the select is a two-bit register code.
module idx_base_mux
    import idx_addr_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] reg_x,
    input  logic [ADDR_W-1:0] reg_y,
    input  logic [ADDR_W-1:0] reg_sp,
    input  logic [ADDR_W-1:0] reg_pc,
    input  base_e             sel,
    output logic [ADDR_W-1:0] base_val
);

    localparam int NREG = 4;

    logic [NREG-1:0][ADDR_W-1:0] bank;
    logic [NREG-1:0][ADDR_W-1:0] gated;

    assign bank[0] = reg_x;
    assign bank[1] = reg_y;
    assign bank[2] = reg_sp;
    assign bank[3] = reg_pc;

    for (genvar g = 0; g < NREG; g++) begin : g_gate
        // Keep a register only when its code is selected.
        assign gated[g] = (sel == base_e'(g)) ? bank[g] : '0;
    end

    // OR the gated registers into the single selected base.
    always_comb begin
        base_val = '0;
        for (int i = 0; i < NREG; i++) begin
            base_val = base_val | gated[i];
        end
    end

endmodule

// File: rtl/idx_offset.sv
// Module: idx_offset
// Forms the two's-complement offset for the decoded mode and the number
// of extension bytes the mode consumes. Assumes ADDR_W == 2*BYTE_W.
module idx_offset
    import idx_addr_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 2 * BYTE_W
) (
    input  dec_t              dec,
    input  logic [BYTE_W-1:0] ext_hi,
    input  logic [BYTE_W-1:0] ext_lo,
    input  logic [BYTE_W-1:0] acc_a,
    input  logic [BYTE_W-1:0] acc_b,
    output logic [ADDR_W-1:0] offset,
    output logic [1:0]        ext_cnt
);

    localparam int K5_W   = 5;
    localparam int STEP_W = 4;

    logic [ADDR_W-1:0] k5_ext;
    logic [ADDR_W-1:0] k9_ext;
    logic [ADDR_W-1:0] k16_val;
    logic [ADDR_W-1:0] acc_ext;
    logic [ADDR_W-1:0] step_ext;

    assign k5_ext  = {{(ADDR_W-K5_W){dec.k5[K5_W-1]}}, dec.k5};
    assign k9_ext  = {{(ADDR_W-BYTE_W-1){dec.k9_sign}}, dec.k9_sign, ext_hi};
    assign k16_val = {ext_hi, ext_lo};

    // Zero-extend the chosen accumulator (D is A:B).
    always_comb begin
        unique case (dec.acc)
            OFS_A:   acc_ext = {{(ADDR_W-BYTE_W){1'b0}}, acc_a};
            OFS_B:   acc_ext = {{(ADDR_W-BYTE_W){1'b0}}, acc_b};
            OFS_D:   acc_ext = {acc_a, acc_b};
            default: acc_ext = '0;
        endcase
    end

    // Map the step nibble: 0..7 -> +1..+8, 8..15 -> -8..-1.
    always_comb begin
        if (dec.step[STEP_W-1]) begin
            step_ext = {{(ADDR_W-STEP_W){1'b1}}, dec.step};
        end else begin
            step_ext = {{(ADDR_W-STEP_W){1'b0}}, dec.step} + ADDR_W'(1);
        end
    end

    // Choose the offset and extension count for the mode.
    always_comb begin
        offset  = '0;
        ext_cnt = 2'd0;
        unique case (dec.mode)
            MD_K5:   offset = k5_ext;
            MD_K9:   begin offset = k9_ext;  ext_cnt = 2'd1; end
            MD_K16:  begin offset = k16_val; ext_cnt = 2'd2; end
            MD_ACC:  offset = acc_ext;
            MD_PRE,
            MD_POST: offset = step_ext;
            default: begin offset = '0; ext_cnt = 2'd0; end
        endcase
    end

endmodule

// File: rtl/idx_addr_gen.sv
// Module: idx_addr_gen (top)
// Combinational indexed address generator: decodes a postbyte, adds the
// selected base and offset modulo 2^ADDR_W, and requests base writeback
// for auto-step modes. Holds no state; the caller registers the results.
module idx_addr_gen
    import idx_addr_pkg::*;
#(
    parameter  int BYTE_W = 8,
    localparam int ADDR_W = 2 * BYTE_W
) (
    input  logic [7:0]        postbyte,
    input  logic [BYTE_W-1:0] ext_hi,
    input  logic [BYTE_W-1:0] ext_lo,
    input  logic [ADDR_W-1:0] reg_x,
    input  logic [ADDR_W-1:0] reg_y,
    input  logic [ADDR_W-1:0] reg_sp,
    input  logic [ADDR_W-1:0] reg_pc,
    input  logic [BYTE_W-1:0] acc_a,
    input  logic [BYTE_W-1:0] acc_b,
    output logic [ADDR_W-1:0] ea,
    output logic [1:0]        ext_cnt,
    output logic              wb_en,
    output logic [1:0]        wb_sel,
    output logic [ADDR_W-1:0] wb_val,
    output logic              illegal
);

    dec_t              dec;
    logic [ADDR_W-1:0] base_val;
    logic [ADDR_W-1:0] offset;
    logic [1:0]        ofs_cnt;
    logic [ADDR_W-1:0] sum;
    logic              auto_md;

    idx_decode u_dec (
        .pb  (postbyte),
        .dec (dec)
    );

    idx_base_mux #(.ADDR_W(ADDR_W)) u_base (
        .reg_x    (reg_x),
        .reg_y    (reg_y),
        .reg_sp   (reg_sp),
        .reg_pc   (reg_pc),
        .sel      (dec.base),
        .base_val (base_val)
    );

    idx_offset #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_ofs (
        .dec     (dec),
        .ext_hi  (ext_hi),
        .ext_lo  (ext_lo),
        .acc_a   (acc_a),
        .acc_b   (acc_b),
        .offset  (offset),
        .ext_cnt (ofs_cnt)
    );

    assign sum     = base_val + offset;
    assign auto_md = (dec.mode == MD_PRE) || (dec.mode == MD_POST);

    // Pick the address and writeback outputs for the decoded mode.
    always_comb begin
        illegal = (dec.mode == MD_BAD);
        ext_cnt = illegal ? 2'd0 : ofs_cnt;
        wb_en   = auto_md;
        wb_sel  = auto_md ? dec.base : 2'd0;
        wb_val  = auto_md ? sum : '0;
        unique case (dec.mode)
            MD_POST: ea = base_val;
            MD_BAD:  ea = '0;
            default: ea = sum;
        endcase
    end

endmodule

// File: rtl/idx_addr_gen_chk.sv
// Module: idx_addr_gen_chk
// Property checker bound to idx_addr_gen; relates its ports with
// immediate assertions since the block has no clock.
module idx_addr_gen_chk #(
    parameter  int BYTE_W = 8,
    localparam int ADDR_W = 2 * BYTE_W
) (
    input logic [7:0]        postbyte,
    input logic [BYTE_W-1:0] ext_hi,
    input logic [BYTE_W-1:0] ext_lo,
    input logic [ADDR_W-1:0] reg_x,
    input logic [ADDR_W-1:0] reg_y,
    input logic [ADDR_W-1:0] reg_sp,
    input logic [ADDR_W-1:0] reg_pc,
    input logic [BYTE_W-1:0] acc_a,
    input logic [BYTE_W-1:0] acc_b,
    input logic [ADDR_W-1:0] ea,
    input logic [1:0]        ext_cnt,
    input logic              wb_en,
    input logic [1:0]        wb_sel,
    input logic [ADDR_W-1:0] wb_val,
    input logic              illegal
);

    logic [ADDR_W-1:0] old_base;

    // Register named by the writeback select, taken from the inputs.
    always_comb begin
        unique case (wb_sel)
            2'd0:    old_base = reg_x;
            2'd1:    old_base = reg_y;
            2'd2:    old_base = reg_sp;
            default: old_base = reg_pc;
        endcase
    end

    // Check port relations on every input change.
    always_comb begin
        p_short_no_ext_r1: assert (postbyte[5] || (ext_cnt == 2'd0 && !wb_en));
        p_ext_range_r2:    assert (ext_cnt != 2'd3);
        p_wb_not_pc_r5:    assert (!wb_en || wb_sel != 2'd3);
        p_pre_uses_new_r6: assert (!(wb_en && !postbyte[4]) || ea == wb_val);
        p_post_uses_old_r7: assert (!(wb_en && postbyte[4]) || ea == old_base);
        p_bad_quiet_r9:    assert (!illegal || (!wb_en && ext_cnt == 2'd0 && ea == '0));
        p_fixed_no_wb_r10: assert (postbyte[7:5] != 3'b111 || !wb_en);
        p_bad_only_111_r11: assert (!illegal || postbyte[7:5] == 3'b111);
    end

    logic unused_ok;
    assign unused_ok = ^{ext_hi, ext_lo, acc_a, acc_b};

endmodule

bind idx_addr_gen idx_addr_gen_chk #(.BYTE_W(BYTE_W)) u_chk (.*);

// File: tb/idx_addr_gen_test.sv
`timescale 1ns/1ps
module idx_addr_gen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  postbyte = '0;
    logic [7:0]  ext_hi = '0, ext_lo = '0, acc_a = '0, acc_b = '0;
    logic [15:0] reg_x = '0, reg_y = '0, reg_sp = '0, reg_pc = '0;
    logic [15:0] ea, wb_val;
    logic [1:0]  ext_cnt, wb_sel;
    logic        wb_en, illegal;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    idx_addr_gen uut (
        .postbyte(postbyte), .ext_hi(ext_hi), .ext_lo(ext_lo),
        .reg_x(reg_x), .reg_y(reg_y), .reg_sp(reg_sp), .reg_pc(reg_pc),
        .acc_a(acc_a), .acc_b(acc_b), .ea(ea), .ext_cnt(ext_cnt),
        .wb_en(wb_en), .wb_sel(wb_sel), .wb_val(wb_val), .illegal(illegal)
    );

    task automatic chk(input string req, input string what,
                       input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, got, exp);
        end
    endtask

    task automatic apply(input logic [7:0] pb, input logic [7:0] hi, input logic [7:0] lo);
        @(negedge clk);
        postbyte = pb; ext_hi = hi; ext_lo = lo;
        #1;
    endtask

    task automatic std_regs();
        reg_x = 16'h1000; reg_y = 16'h2000; reg_sp = 16'h3000; reg_pc = 16'h4000;
        acc_a = 8'h12; acc_b = 8'h34;
    endtask

    task automatic t_idle();
        apply(8'h00, 8'h00, 8'h00);
        chk("R1", "idle ea", ea, 16'h0000);
        chk("R11", "idle illegal", {15'd0, illegal}, 16'd0);
        chk("R10", "idle wb_en", {15'd0, wb_en}, 16'd0);
    endtask

    task automatic t_k5();
        std_regs();
        apply(8'h0F, 8'hAA, 8'hBB);
        chk("R1", "X+15 ea", ea, 16'h100F);
        chk("R1", "X+15 ext", {14'd0, ext_cnt}, 16'd0);
        chk("R10", "k5 wb_en", {15'd0, wb_en}, 16'd0);
        apply(8'h50, 8'h00, 8'h00);
        chk("R1", "Y-16 ea", ea, 16'h1FF0);
        apply(8'h9F, 8'h00, 8'h00);
        chk("R1", "SP-1 ea", ea, 16'h2FFF);
        apply(8'hC1, 8'h00, 8'h00);
        chk("R1", "PC+1 ea", ea, 16'h4001);
        chk("R11", "k5 illegal", {15'd0, illegal}, 16'd0);
    endtask

    task automatic t_k9();
        std_regs();
        apply(8'hE0, 8'h80, 8'h55);
        chk("R2", "X+128 ea", ea, 16'h1080);
        chk("R2", "k9 ext", {14'd0, ext_cnt}, 16'd1);
        apply(8'hE9, 8'h00, 8'h55);
        chk("R2", "Y-256 ea", ea, 16'h1F00);
        chk("R10", "k9 wb_en", {15'd0, wb_en}, 16'd0);
    endtask

    task automatic t_k16();
        std_regs();
        apply(8'hF2, 8'h12, 8'h34);
        chk("R3", "SP+1234 ea", ea, 16'h4234);
        chk("R3", "k16 ext", {14'd0, ext_cnt}, 16'd2);
        reg_x = 16'hFFF0;
        apply(8'hE2, 8'h00, 8'h20);
        chk("R8", "k16 wrap ea", ea, 16'h0010);
        chk("R11", "k16 illegal", {15'd0, illegal}, 16'd0);
    endtask

    task automatic t_acc();
        std_regs();
        apply(8'hE4, 8'h00, 8'h00);
        chk("R4", "X+A ea", ea, 16'h1012);
        apply(8'hED, 8'h00, 8'h00);
        chk("R4", "Y+B ea", ea, 16'h2034);
        apply(8'hFE, 8'h00, 8'h00);
        chk("R4", "PC+D ea", ea, 16'h5234);
        chk("R4", "acc ext", {14'd0, ext_cnt}, 16'd0);
        chk("R10", "acc wb_en", {15'd0, wb_en}, 16'd0);
        acc_a = 8'hFF; acc_b = 8'hFF;
        apply(8'hE4, 8'h00, 8'h00);
        chk("R4", "A unsigned ea", ea, 16'h10FF);
    endtask

    task automatic t_pre();
        std_regs();
        apply(8'h23, 8'h00, 8'h00);
        chk("R5", "pre+4 wb_en", {15'd0, wb_en}, 16'd1);
        chk("R5", "pre+4 sel", {14'd0, wb_sel}, 16'd0);
        chk("R5", "pre+4 wb_val", wb_val, 16'h1004);
        chk("R6", "pre+4 ea", ea, 16'h1004);
        apply(8'hAF, 8'h00, 8'h00);
        chk("R5", "pre-1 sel", {14'd0, wb_sel}, 16'd2);
        chk("R5", "pre-1 wb_val", wb_val, 16'h2FFF);
        chk("R6", "pre-1 ea", ea, 16'h2FFF);
        chk("R5", "pre ext", {14'd0, ext_cnt}, 16'd0);
    endtask

    task automatic t_post();
        std_regs();
        apply(8'h77, 8'h00, 8'h00);
        chk("R7", "post+8 ea", ea, 16'h2000);
        chk("R5", "post+8 wb_val", wb_val, 16'h2008);
        chk("R5", "post+8 sel", {14'd0, wb_sel}, 16'd1);
        apply(8'h38, 8'h00, 8'h00);
        chk("R7", "post-8 ea", ea, 16'h1000);
        chk("R5", "post-8 wb_val", wb_val, 16'h0FF8);
        chk("R11", "post illegal", {15'd0, illegal}, 16'd0);
    endtask

    task automatic t_wrap_auto();
        std_regs();
        reg_x = 16'hFFFE;
        apply(8'h23, 8'h00, 8'h00);
        chk("R8", "pre wrap ea", ea, 16'h0002);
        chk("R8", "pre wrap wb_val", wb_val, 16'h0002);
        reg_sp = 16'h0003;
        apply(8'hB8, 8'h00, 8'h00);
        chk("R8", "post wrap ea", ea, 16'h0003);
        chk("R8", "post wrap wb_val", wb_val, 16'hFFFB);
    endtask

    task automatic t_illegal();
        std_regs();
        apply(8'hE3, 8'h12, 8'h34);
        chk("R9", "E3 illegal", {15'd0, illegal}, 16'd1);
        chk("R9", "E3 wb_en", {15'd0, wb_en}, 16'd0);
        chk("R9", "E3 ea", ea, 16'h0000);
        chk("R9", "E3 ext", {14'd0, ext_cnt}, 16'd0);
        apply(8'hFF, 8'h12, 8'h34);
        chk("R9", "FF illegal", {15'd0, illegal}, 16'd1);
        chk("R9", "FF wb_en", {15'd0, wb_en}, 16'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_idle();
        t_k5();
        t_k9();
        t_k16();
        t_acc();
        t_pre();
        t_post();
        t_wrap_auto();
        t_illegal();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule